// File: doc/BRIEF.md
# Pixel Blend Unit

This block is the colour-combine stage at the back of a render-output path. It handles one colour target stored as four 8-bit unsigned-normalised channels. Each clock it can accept one pixel beat: the shaded source colour, the colour already in the framebuffer, a constant blend colour, a 32-bit control word and a 4-bit channel write mask. It returns the combined pixel together with per-channel write enables.

The control word holds two independent equations, one for red/green/blue and one for alpha. Each equation has a source factor, a destination factor and an operation. When a factor code names a colour quantity and it appears in the alpha equation, the block uses the matching alpha quantity instead. The identity setting is treated as a plain overwrite.

The output follows the input after a fixed two-cycle latency. The valid flag travels with the data through both stages.

Top module: `pix_blend_unit`

## Requirements
- R1: A beat accepted with `in_valid` high in cycle n appears at the outputs with `out_valid` high after the second rising edge. A cycle without `in_valid` produces `out_valid` low two cycles later. Each pixel word packs red in bits 7:0, green in 15:8, blue in 23:16 and alpha in 31:24.
- R2: A synchronous active-high `rst` clears both pipeline stages. After an edge with `rst` high, `out_valid` is low and `out_wen` is zero.
- R3: Control word fields are: colour source factor in bits 4:0, colour operation in 7:5, colour destination factor in 12:8, alpha source factor in 20:16, alpha operation in 23:21 and alpha destination factor in 28:24. The factor codes are: 0 zero, 1 one, 4 source channel, 5 one minus source channel, 6 source alpha, 7 one minus source alpha, 8 destination channel, 9 one minus destination channel, 10 destination alpha, 11 one minus destination alpha, 12 and 14 constant channel, 13 and 15 one minus constant channel.
- R4: Factor codes 2, 3 and 17 to 31 act as zero.
- R5: Operation codes are: 0 add, 1 source term minus destination term, 4 destination term minus source term. Codes 5 to 7 behave as add. Add saturates at 255 and both subtractions saturate at 0.
- R6: Operation 2 gives the per-channel minimum and operation 3 the maximum of the raw source and destination values. The factors have no effect under these two operations.
- R7: In the alpha equation, codes 4, 5, 8 and 9 select source alpha, one minus source alpha, destination alpha and one minus destination alpha.
- R8: Factor code 16 gives min(source alpha, 255 minus destination alpha) on red, green and blue, and gives 255 on alpha.
- R9: Control word 0x00010001 passes the source pixel through unchanged.
- R10: `out_wen` bit i is set only when `out_valid` is high and mask bit i was set. Bit 0 is red, bit 1 green, bit 2 blue and bit 3 alpha. A zero mask enables no channel.
- R11: Each factor product is computed as (value*factor + 127) / 255, using integer division.
- R12: Control word 0x07010701 reproduces premultiplied-alpha "over" compositing exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| src_px | input | 32 | Source colour, RGBA8 |
| dst_px | input | 32 | Framebuffer colour, RGBA8 |
| const_px | input | 32 | Constant blend colour, RGBA8 |
| blend_ctl | input | 32 | Packed colour and alpha equations |
| wr_mask | input | 4 | Channel write mask |
| out_valid | output | 1 | Result beat present |
| out_px | output | 32 | Blended colour, RGBA8 |
| out_wen | output | 4 | Per-channel write enables |

## Verification
A wrong factor decode or a wrong alpha remap shows up as a wrong byte in `out_px`, exactly two cycles after the beat enters. Each vector is chosen so that a misread code changes at least one channel. A stage whose valid or mask is held or dropped shows up as a wrong `out_valid` or `out_wen` in that same cycle. A reset that fails to clear a stage leaves a phantom beat visible one edge after reset. The vectors are streamed back to back, so any mix-up of fields between neighbouring beats is also exposed.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
    localparam int CW     = 8;
    localparam int NCH    = 4;
    localparam int PIX_W  = CW * NCH;
    localparam int A_IDX  = NCH - 1;
    localparam int CODE_W = 5;
    localparam int OP_W   = 3;
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};
    localparam logic [PIX_W-1:0] IDENTITY_CTL = 32'h0001_0001;

    typedef struct packed {
        logic [CODE_W-1:0] dst_f;
        logic [OP_W-1:0]   op;
        logic [CODE_W-1:0] src_f;
    } eqn_t;

    function automatic logic [CW-1:0] unorm_mul(input logic [CW-1:0] a, input logic [CW-1:0] b);
        logic [2*CW-1:0] p;
        p = (2*CW)'(a) * (2*CW)'(b) + (2*CW)'(MAXV >> 1);
        return CW'(p / (2*CW)'(MAXV));
    endfunction

    function automatic logic [CW-1:0] pick_factor(
        input logic [CODE_W-1:0] code, input logic alpha_lane,
        input logic [CW-1:0] s, input logic [CW-1:0] d, input logic [CW-1:0] k,
        input logic [CW-1:0] sa, input logic [CW-1:0] da);
        logic [CODE_W-1:0] c;
        c = code;
        if (alpha_lane) begin
            case (code)
                5'd4:    c = 5'd6;
                5'd5:    c = 5'd7;
                5'd8:    c = 5'd10;
                5'd9:    c = 5'd11;
                default: c = code;
            endcase
        end
        case (c)
            5'd1:          return MAXV;
            5'd4:          return s;
            5'd5:          return MAXV - s;
            5'd6:          return sa;
            5'd7:          return MAXV - sa;
            5'd8:          return d;
            5'd9:          return MAXV - d;
            5'd10:         return da;
            5'd11:         return MAXV - da;
            5'd12, 5'd14:  return k;
            5'd13, 5'd15:  return MAXV - k;
            5'd16:         return alpha_lane ? MAXV : ((sa < (MAXV - da)) ? sa : (MAXV - da));
            default:       return '0;
        endcase
    endfunction
endpackage

// File: rtl/pxb_scale.sv
module pxb_scale
    import pxb_pkg::*;
#(
    parameter bit IS_ALPHA = 1'b0
) (
    input  logic [CODE_W-1:0] src_code,
    input  logic [CODE_W-1:0] dst_code,
    input  logic [CW-1:0]     s_ch,
    input  logic [CW-1:0]     d_ch,
    input  logic [CW-1:0]     k_ch,
    input  logic [CW-1:0]     s_alpha,
    input  logic [CW-1:0]     d_alpha,
    output logic [CW-1:0]     s_term,
    output logic [CW-1:0]     d_term
);
    logic [CW-1:0] sf, df;

    always_comb begin
        sf     = pick_factor(src_code, IS_ALPHA, s_ch, d_ch, k_ch, s_alpha, d_alpha);
        df     = pick_factor(dst_code, IS_ALPHA, s_ch, d_ch, k_ch, s_alpha, d_alpha);
        s_term = unorm_mul(s_ch, sf);
        d_term = unorm_mul(d_ch, df);
    end
endmodule

// File: rtl/pxb_combine.sv
module pxb_combine
    import pxb_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic [CW-1:0]   s_raw,
    input  logic [CW-1:0]   d_raw,
    input  logic [CW-1:0]   s_term,
    input  logic [CW-1:0]   d_term,
    output logic [CW-1:0]   res
);
    logic [CW:0] sum;

    always_comb begin
        sum = {1'b0, s_term} + {1'b0, d_term};
        case (op)
            3'd1:    res = (s_term >= d_term) ? (s_term - d_term) : '0;
            3'd2:    res = (s_raw < d_raw) ? s_raw : d_raw;
            3'd3:    res = (s_raw > d_raw) ? s_raw : d_raw;
            3'd4:    res = (d_term >= s_term) ? (d_term - s_term) : '0;
            default: res = sum[CW] ? MAXV : sum[CW-1:0];
        endcase
    end

    always_comb begin
        // R6
        if (op == 3'd2) min_bound_chk: assert (res <= s_raw && res <= d_raw);
        // R6
        if (op == 3'd3) max_bound_chk: assert (res >= s_raw && res >= d_raw);
    end
endmodule

// File: rtl/pix_blend_unit.sv
module pix_blend_unit
    import pxb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] src_px,
    input  logic [PIX_W-1:0] dst_px,
    input  logic [PIX_W-1:0] const_px,
    input  logic [PIX_W-1:0] blend_ctl,
    input  logic [NCH-1:0]   wr_mask,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_px,
    output logic [NCH-1:0]   out_wen
);
    typedef struct packed {
        logic                    valid;
        logic                    bypass;
        logic [NCH-1:0]          mask;
        logic [OP_W-1:0]         cop;
        logic [OP_W-1:0]         aop;
        logic [NCH-1:0][CW-1:0]  s_raw;
        logic [NCH-1:0][CW-1:0]  d_raw;
        logic [NCH-1:0][CW-1:0]  s_term;
        logic [NCH-1:0][CW-1:0]  d_term;
    } st1_t;

    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] px;
        logic [NCH-1:0]   wen;
    } st2_t;

    st1_t s1_d, s1_q;
    st2_t s2_d, s2_q;
    eqn_t ceq, aeq;
    logic [NCH-1:0][CW-1:0] sterm_w, dterm_w, res_w;

    assign ceq = eqn_t'(blend_ctl[12:0]);
    assign aeq = eqn_t'(blend_ctl[28:16]);

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        localparam bit LANE_A = (g == A_IDX);
        pxb_scale #(.IS_ALPHA(LANE_A)) u_scale (
            .src_code (LANE_A ? aeq.src_f : ceq.src_f),
            .dst_code (LANE_A ? aeq.dst_f : ceq.dst_f),
            .s_ch     (src_px[g*CW +: CW]),
            .d_ch     (dst_px[g*CW +: CW]),
            .k_ch     (const_px[g*CW +: CW]),
            .s_alpha  (src_px[A_IDX*CW +: CW]),
            .d_alpha  (dst_px[A_IDX*CW +: CW]),
            .s_term   (sterm_w[g]),
            .d_term   (dterm_w[g])
        );
        pxb_combine u_comb (
            .op     (LANE_A ? s1_q.aop : s1_q.cop),
            .s_raw  (s1_q.s_raw[g]),
            .d_raw  (s1_q.d_raw[g]),
            .s_term (s1_q.s_term[g]),
            .d_term (s1_q.d_term[g]),
            .res    (res_w[g])
        );
    end

    always_comb begin
        s1_d.valid  = in_valid;
        s1_d.bypass = (blend_ctl == IDENTITY_CTL);
        s1_d.mask   = wr_mask;
        s1_d.cop    = ceq.op;
        s1_d.aop    = aeq.op;
        s1_d.s_raw  = src_px;
        s1_d.d_raw  = dst_px;
        s1_d.s_term = sterm_w;
        s1_d.d_term = dterm_w;

        s2_d.valid  = s1_q.valid;
        s2_d.px     = s1_q.bypass ? PIX_W'(s1_q.s_raw) : PIX_W'(res_w);
        s2_d.wen    = s1_q.valid ? s1_q.mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.valid;
    assign out_px    = s2_q.px;
    assign out_wen   = s2_q.wen;

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);
    // R1
    idle_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);
    // R10
    wen_mask_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_wen == $past(wr_mask, 2)));
    // R10
    wen_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_wen == '0));
    // R9
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(blend_ctl, 2) == IDENTITY_CTL) |-> (out_px == $past(src_px, 2)));
endmodule

// File: tb/pix_blend_unit_test.sv
module pix_blend_unit_test;
    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] kc;
        logic [31:0] ctl;
        logic [3:0]  mask;
        logic [31:0] exp_px;
        logic [3:0]  exp_wen;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'd9,  32'h80402010, 32'hFFFFFFFF, 32'h0, 32'h00010001, 4'hF, 32'h80402010, 4'hF}, // R9 pass-through
        '{8'd12, 32'h80402010, 32'hFFFFFFFF, 32'h0, 32'h07010701, 4'hF, 32'hFFBF9F8F, 4'hF}, // R12 premultiplied over
        '{8'd3,  32'hAABBCCDD, 32'h11223344, 32'h0, 32'h01000100, 4'h5, 32'h11223344, 4'h5}, // R3 zero/one
        '{8'd5,  32'h40404040, 32'h10805010, 32'h0, 32'h01210121, 4'hF, 32'h30000030, 4'hF}, // R5 subtract clamp
        '{8'd5,  32'h80C0F001, 32'h80808080, 32'h0, 32'h01010101, 4'hF, 32'hFFFFFF81, 4'hF}, // R5 add clamp
        '{8'd6,  32'h20F01080, 32'h80108020, 32'h0, 32'h00600040, 4'hF, 32'h80101020, 4'hF}, // R6 min rgb, max a
        '{8'd5,  32'h10101010, 32'h20308005, 32'h0, 32'h01810181, 4'hF, 32'h10207000, 4'hF}, // R5 reverse subtract
        '{8'd4,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h1F031102, 4'hF, 32'h00000000, 4'hF}, // R4 undefined codes
        '{8'd3,  32'hFFFFFFFF, 32'h00000000, 32'h40C08000, 32'h0F0E0D0C, 4'hF, 32'h40C08000, 4'hF}, // R3 constant
        '{8'd7,  32'h80112233, 32'hFF000000, 32'h0, 32'h09040001, 4'hF, 32'h40112233, 4'hF}, // R7 alpha remap
        '{8'd8,  32'hC0FF8040, 32'hA0000000, 32'h0, 32'h00100010, 4'hF, 32'hC05F3018, 4'hF}, // R8 saturate factor
        '{8'd11, 32'h80808080, 32'hFF40FF80, 32'h0, 32'h00080008, 4'hF, 32'h80208040, 4'hF}, // R11 rounding
        '{8'd10, 32'h80402010, 32'hFFFFFFFF, 32'h0, 32'h07010701, 4'h0, 32'hFFBF9F8F, 4'h0}, // R10 zero mask
        '{8'd5,  32'h01020304, 32'h10101010, 32'h0, 32'h01E101E1, 4'hF, 32'h11121314, 4'hF}  // R5 op fallback
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] src_px = '0, dst_px = '0, const_px = '0, blend_ctl = '0;
    logic [3:0]  wr_mask = '0;
    logic        out_valid;
    logic [31:0] out_px;
    logic [3:0]  out_wen;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pix_blend_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_px(src_px), .dst_px(dst_px),
        .const_px(const_px), .blend_ctl(blend_ctl), .wr_mask(wr_mask),
        .out_valid(out_valid), .out_px(out_px), .out_wen(out_wen)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        in_valid  = vld;
        src_px    = v.src;
        dst_px    = v.dst;
        const_px  = v.kc;
        blend_ctl = v.ctl;
        wr_mask   = v.mask;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 reset valid", 32'(out_valid), 32'd0);
        chk("R2 reset wen", 32'(out_wen), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) begin
                chk($sformatf("R1 valid vec%0d", i - 2), 32'(out_valid), 32'd1);
                chk($sformatf("R%0d px vec%0d", VECS[i-2].req, i - 2), out_px, VECS[i-2].exp_px);
                chk($sformatf("R10 wen vec%0d", i - 2), 32'(out_wen), 32'(VECS[i-2].exp_wen));
            end
            if (i < NV) drive(VECS[i], 1'b1);
            else drive(VECS[0], 1'b0);
            @(negedge clk);
        end

        // R1: idle input gives idle output and no write enables
        chk("R1 idle valid", 32'(out_valid), 32'd0);
        chk("R10 idle wen", 32'(out_wen), 32'd0);

        // R2: reset in mid-flight drops the beat
        drive(VECS[1], 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R2 flush valid", 32'(out_valid), 32'd0);
        chk("R2 flush wen", 32'(out_wen), 32'd0);
        drive(VECS[1], 1'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 after flush", 32'(out_valid), 32'd0);

        // R6: min with different factors gives same result (factors ignored)
        drive('{8'd6, 32'h20F01080, 32'h80108020, 32'h0, 32'h1F5F1F5F, 4'hF, 32'h0, 4'hF}, 1'b1);
        @(negedge clk);
        drive(VECS[0], 1'b0);
        @(negedge clk);
        chk("R6 factors ignored", out_px, 32'h20101020);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule